// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle the surrounding datapath presents an operation code, a register operand (normally the accumulator or an index register), a memory operand and the current condition flags. The block returns a result byte, a proposed new flag vector and a mask that says which flags the operation is allowed to write.

Each operation family touches its own subset of the flags. Carry acts as an inverted borrow for subtraction and compare, and it is the ninth bit for rotates. All arithmetic is binary. There is no decimal mode. Writing the result back, fetching operands and deciding where a shift result goes are left to the datapath. Single-operand operations work on the memory operand, so a datapath that shifts the accumulator routes it to that input.

Top module: `cpu_alu8`

## Requirements
- R1: Op code 0 (add with carry) gives result = low 8 bits of reg + mem + C, and the new C is bit 8 of that 9-bit sum. All four flags are written.
- R2: Op code 1 (subtract with borrow) gives result = reg − mem − (1 − C), computed as reg + ~mem + C. The new C is bit 8 of that sum, so a set C means no borrow occurred. All four flags are written.
- R3: For op codes 0 and 1, V is set exactly when the signed result falls outside −128..127. This is the case where the two addends (with mem inverted for subtraction) share a sign and the sum's sign differs.
- R4: Whenever N or Z is written, N equals bit 7 of result and Z is set exactly when result is 0x00.
- R5: Op codes 2 and 3 return mem + 1 and mem − 1, wrapping modulo 256. They write only N and Z.
- R6: Op codes 4, 5 and 6 return reg AND mem, reg OR mem and reg XOR mem. They write only N and Z.
- R7: Op code 7 shifts mem left, with bit 7 going to C and 0 entering bit 0. Op code 8 shifts mem right, with bit 0 going to C and 0 entering bit 7. Both write N, Z and C.
- R8: Op code 9 rotates mem left through carry, and op code 10 rotates it right through carry. The old C enters the vacated bit and the bit shifted out becomes the new C. Both write N, Z and C.
- R9: Op code 11 (compare) returns reg − mem modulo 256. It sets C when reg ≥ mem (unsigned), sets Z only when they are equal, and takes N from bit 7 of the difference. It does not write V, and the incoming carry has no effect.
- R10: The flag vectors are ordered {N, Z, C, V} on bits [3:0]. flags_we marks the flags an operation writes. Every flag not written appears on flags_out unchanged from flags_in.
- R11: Op codes 12 to 15 pass reg to result and write no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code, see requirements |
| opnd_reg | input | 8 | Register operand |
| opnd_mem | input | 8 | Memory operand |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 8 | Operation result |
| flags_out | output | 4 | Updated flags {N,Z,C,V} |
| flags_we | output | 4 | Per-flag write mask {N,Z,C,V} |

## Verification
The block holds no state, so a fault shows at the ports in the same evaluation as the inputs that expose it. It never hides behind later cycles. A wrong carry-in choice or operand inversion corrupts result and C together. A wrong write mask does two visible things: a flag the operation should leave alone changes, or the mask disagrees with the operation family. The vector table covers each family's flag subset and edge values. A sweep compares add, subtract and compare with an integer model, which also exposes errors in overflow sign logic and in carry-as-borrow polarity.

// File: rtl/cpu_alu8.sv
module cpu_alu8 #(
  parameter int W = 8
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_reg,
  input  logic [W-1:0] opnd_mem,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic [3:0]   flags_we
);
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  localparam logic [3:0] OP_ADC = 4'd0, OP_SBC = 4'd1, OP_INC = 4'd2, OP_DEC = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_SHL = 4'd7,
                         OP_SHR = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10, OP_CMP = 4'd11;

  logic          use_inv;
  logic          cin;
  logic [W-1:0]  addend;
  logic [W:0]    sum;
  logic          ovf;

  assign use_inv = (op_sel == OP_SBC) || (op_sel == OP_CMP);
  assign addend  = use_inv ? ~opnd_mem : opnd_mem;
  assign cin     = (op_sel == OP_CMP) ? 1'b1 : flags_in[FC];
  assign sum     = {1'b0, opnd_reg} + {1'b0, addend} + {{W{1'b0}}, cin};
  assign ovf     = (opnd_reg[W-1] == addend[W-1]) && (sum[W-1] != opnd_reg[W-1]);

  logic [3:0] newf;

  always_comb begin
    result   = opnd_reg;
    flags_we = 4'b0000;
    newf     = flags_in;
    case (op_sel)
      OP_ADC, OP_SBC: begin
        result   = sum[W-1:0];
        flags_we = 4'b1111;
        newf[FC] = sum[W];
        newf[FV] = ovf;
      end
      OP_CMP: begin
        result   = sum[W-1:0];
        flags_we = 4'b1110;
        newf[FC] = sum[W];
      end
      OP_INC: begin result = opnd_mem + 1'b1; flags_we = 4'b1100; end
      OP_DEC: begin result = opnd_mem - 1'b1; flags_we = 4'b1100; end
      OP_AND: begin result = opnd_reg & opnd_mem; flags_we = 4'b1100; end
      OP_OR:  begin result = opnd_reg | opnd_mem; flags_we = 4'b1100; end
      OP_XOR: begin result = opnd_reg ^ opnd_mem; flags_we = 4'b1100; end
      OP_SHL: begin
        result   = {opnd_mem[W-2:0], 1'b0};
        newf[FC] = opnd_mem[W-1];
        flags_we = 4'b1110;
      end
      OP_SHR: begin
        result   = {1'b0, opnd_mem[W-1:1]};
        newf[FC] = opnd_mem[0];
        flags_we = 4'b1110;
      end
      OP_ROL: begin
        result   = {opnd_mem[W-2:0], flags_in[FC]};
        newf[FC] = opnd_mem[W-1];
        flags_we = 4'b1110;
      end
      OP_ROR: begin
        result   = {flags_in[FC], opnd_mem[W-1:1]};
        newf[FC] = opnd_mem[0];
        flags_we = 4'b1110;
      end
      default: ;
    endcase
    if (flags_we[FN]) newf[FN] = result[W-1];
    if (flags_we[FZ]) newf[FZ] = (result == '0);
  end

  assign flags_out = newf;
endmodule

// File: rtl/cpu_alu8_chk.sv
module cpu_alu8_chk #(
  parameter int W = 8
) (
  input logic [3:0]   op_sel,
  input logic [W-1:0] opnd_reg,
  input logic [W-1:0] opnd_mem,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic [3:0]   flags_out,
  input logic [3:0]   flags_we
);
  always_comb begin
    a_r10_untouched_flags_kept: assert ((flags_out & ~flags_we) == (flags_in & ~flags_we));
    if (flags_we[3]) begin
      a_r4_neg_from_msb: assert (flags_out[3] == result[W-1]);
    end
    if (flags_we[2]) begin
      a_r4_zero_on_empty: assert (flags_out[2] == (result == '0));
    end
    if (op_sel == 4'd0) begin
      a_r1_carry_is_ninth_bit: assert ({flags_out[1], result} ==
        ({1'b0, opnd_reg} + {1'b0, opnd_mem} + {{W{1'b0}}, flags_in[1]}));
    end
    if (op_sel >= 4'd2 && op_sel <= 4'd6) begin
      a_r5_r6_only_nz_written: assert (flags_we == 4'b1100);
    end
    if (op_sel == 4'd11) begin
      a_r9_cmp_carry_ge: assert (flags_out[1] == (opnd_reg >= opnd_mem));
      a_r9_cmp_no_overflow_write: assert (!flags_we[0]);
    end
    if (op_sel >= 4'd12) begin
      a_r11_spare_codes_inert: assert (flags_we == 4'b0000 && result == opnd_reg);
    end
  end
endmodule

bind cpu_alu8 cpu_alu8_chk #(.W(W)) u_chk (.*);

// File: tb/cpu_alu8_test.sv
module cpu_alu8_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] op_sel;
  logic [7:0] opnd_reg, opnd_mem, result;
  logic [3:0] flags_in, flags_out, flags_we;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cpu_alu8 uut (.op_sel(op_sel), .opnd_reg(opnd_reg), .opnd_mem(opnd_mem),
                .flags_in(flags_in), .result(result), .flags_out(flags_out),
                .flags_we(flags_we));

  // {op, reg, mem, flags_in, exp_result, exp_flags, exp_we}
  localparam logic [39:0] VEC [20] = '{
    {4'd0,  8'h50, 8'h50, 4'h0, 8'hA0, 4'h9, 4'hF},
    {4'd0,  8'hFF, 8'h01, 4'h0, 8'h00, 4'h6, 4'hF},
    {4'd0,  8'h7F, 8'h00, 4'h2, 8'h80, 4'h9, 4'hF},
    {4'd1,  8'h50, 8'hF0, 4'h2, 8'h60, 4'h0, 4'hF},
    {4'd1,  8'h50, 8'h30, 4'h0, 8'h1F, 4'h2, 4'hF},
    {4'd1,  8'h80, 8'h01, 4'h2, 8'h7F, 4'h3, 4'hF},
    {4'd2,  8'h00, 8'hFF, 4'h3, 8'h00, 4'h7, 4'hC},
    {4'd3,  8'h00, 8'h00, 4'h0, 8'hFF, 4'h8, 4'hC},
    {4'd4,  8'hF0, 8'h0F, 4'h1, 8'h00, 4'h5, 4'hC},
    {4'd5,  8'h80, 8'h01, 4'h0, 8'h81, 4'h8, 4'hC},
    {4'd6,  8'hAA, 8'hAA, 4'hA, 8'h00, 4'h6, 4'hC},
    {4'd7,  8'h00, 8'h81, 4'h2, 8'h02, 4'h2, 4'hE},
    {4'd8,  8'h00, 8'h01, 4'h8, 8'h00, 4'h6, 4'hE},
    {4'd9,  8'h00, 8'h80, 4'h2, 8'h01, 4'h2, 4'hE},
    {4'd9,  8'h00, 8'h80, 4'h0, 8'h00, 4'h6, 4'hE},
    {4'd10, 8'h00, 8'h01, 4'h2, 8'h80, 4'hA, 4'hE},
    {4'd11, 8'h10, 8'h20, 4'h1, 8'hF0, 4'h9, 4'hE},
    {4'd11, 8'h20, 8'h20, 4'h0, 8'h00, 4'h6, 4'hE},
    {4'd11, 8'h20, 8'h10, 4'h0, 8'h10, 4'h2, 4'hE},
    {4'd15, 8'h3C, 8'h00, 4'hF, 8'h3C, 4'hF, 4'h0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1/R3/R4";
      4'd1: return "R2/R3/R4";
      4'd2, 4'd3: return "R5/R10";
      4'd4, 4'd5, 4'd6: return "R6/R10";
      4'd7, 4'd8: return "R7/R4";
      4'd9, 4'd10: return "R8/R4";
      4'd11: return "R9/R10";
      default: return "R11";
    endcase
  endfunction

  task automatic apply_check(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                             input logic [3:0] fi, input logic [7:0] er,
                             input logic [3:0] ef, input logic [3:0] ew, input string tag);
    @(posedge clk);
    op_sel = op; opnd_reg = a; opnd_mem = b; flags_in = fi;
    @(negedge clk);
    checks++;
    if (result !== er || flags_out !== ef || flags_we !== ew) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h fi=%h: got r=%h f=%h we=%h, expected r=%h f=%h we=%h",
               tag, op, a, b, fi, result, flags_out, flags_we, er, ef, ew);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  initial begin
    op_sel = 4'd0; opnd_reg = 8'h00; opnd_mem = 8'h00; flags_in = 4'h0;
    // idle state after power-up inputs: add of zeros gives zero with Z (R4)
    apply_check(4'd0, 8'h00, 8'h00, 4'h0, 8'h00, 4'h4, 4'hF, "R4 idle");
    foreach (VEC[i]) begin
      logic [39:0] v;
      v = VEC[i];
      apply_check(v[39:36], v[35:28], v[27:20], v[19:16], v[15:8], v[7:4], v[3:0], tag_of(v[39:36]));
    end
    // R11: spare codes leave every flag alone whatever flags_in is
    apply_check(4'd12, 8'h00, 8'hFF, 4'h5, 8'h00, 4'h5, 4'h0, "R11");
    // R9: carry-in ignored by compare
    apply_check(4'd11, 8'h05, 8'h05, 4'h0, 8'h00, 4'h6, 4'hE, "R9 cin");
    // sweep of add, subtract and compare against an integer model (R1 R2 R3 R9)
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 15) begin
        for (int c = 0; c < 2; c++) begin
          for (int k = 0; k < 3; k++) begin
            int s, ss;
            logic [3:0] op, ef, fi;
            logic [7:0] er;
            fi = {2'b00, c[0], 1'b1};
            if (k == 0) begin
              op = 4'd0; s = a + b + c; ss = sx(a) + sx(b) + c;
              er = s[7:0];
              ef = {er[7], er == 8'h00, s > 255, (ss > 127 || ss < -128)};
            end else if (k == 1) begin
              op = 4'd1; s = a - b - (1 - c); ss = sx(a) - sx(b) - (1 - c);
              er = s[7:0];
              ef = {er[7], er == 8'h00, s >= 0, (ss > 127 || ss < -128)};
            end else begin
              op = 4'd11; s = a - b;
              er = s[7:0];
              ef = {er[7], a == b, a >= b, 1'b1};
            end
            apply_check(op, a[7:0], b[7:0], fi, er, ef, (k == 2) ? 4'hE : 4'hF,
                        (k == 0) ? "R1/R3" : (k == 1) ? "R2/R3" : "R9");
          end
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule